// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block gathers single-cycle event pulses from an event ring and a transfer engine into a sticky cause status register. Each implemented cause bit has an enable bit, and software clears status by writing ones to a dedicated clear register. The effective cause is the status ANDed with the enable. In wired mode the block drives a level interrupt that stays high while any enabled status bit is set, so events that are not yet handled keep raising it.

A mode register picks the delivery style. In message mode the level output is held low. Instead, the block emits a one-cycle pulse that carries the effective cause vector each time a new enabled cause appears. The cause positions are fixed: bit 0 is block completion and bit 1 is event write-response error. Bit 9 is descriptor read-response error, bit 10 is data read error, bit 11 is data write error, and bit 14 is invalid descriptor.

Register access uses a plain port with valid, write, address and data. A write is taken in any cycle in which valid and write are both high; there is no back-pressure. Read data always shows the register selected by the address, with no added latency. The register offsets are: 0 cause status (read only), 1 cause enable, 2 clear (write-one-to-clear, reads as zero), 3 mode.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, status and enable read 0 and mode reads 1 (wired). `irq_level` and `msg_valid` are low.
- R2: A pulse on `src_pulse` bit 0, 1, 9, 10, 11 or 14 sets that status bit from the next cycle. Pulses on any other bit have no effect, and those status bits read 0.
- R3: Writing a word to offset 2 clears the status bits where the word has ones. Zero bits, including an all-zero word, leave status unchanged.
- R4: If a source pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R5: With mode 1, `irq_level` is high exactly while some bit is set in both status and enable. It stays high until every such bit is cleared.
- R6: A status bit whose enable is 0 still latches and reads back, but drives neither output.
- R7: With mode 0, `irq_level` stays low. `msg_valid` pulses for one cycle, with `msg_cause` equal to status AND enable, in each cycle where some bit of that product has just gone from 0 to 1. This includes a rise caused by setting an enable bit. `msg_cause` is 0 when `msg_valid` is low.
- R8: The mode register keeps only the low 4 bits of the written word, and the upper bits read 0. Mode values other than 0 and 1 keep both outputs low. Writes to offset 0 are ignored. The enable register keeps only the implemented bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 16 | Single-cycle cause source pulses |
| reg_valid | input | 1 | Register access valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| irq_level | output | 1 | Wired level interrupt |
| msg_valid | output | 1 | Message-mode one-cycle pulse |
| msg_cause | output | 16 | Effective cause vector carried with the pulse |

## Verification
A wrong status bit shows up at `reg_rdata` on offset 0 in the cycle after the pulse or clear that should have changed it. In wired mode it also shows at once on `irq_level`. An error in the previous-cause register shows as a missing or extra `msg_valid` in the first cycle after status or enable changes, or as a repeated pulse for a cause that is already pending. A corrupted enable or mode register can be read back directly. It also changes which output reacts on the next clock.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int CAUSE_W = 16;
  localparam int MODE_W  = 4;

  // fixed cause positions
  localparam int POS_BLK_DONE   = 0;
  localparam int POS_EVT_WR_ERR = 1;
  localparam int POS_DESC_RD    = 9;
  localparam int POS_DATA_RD    = 10;
  localparam int POS_DATA_WR    = 11;
  localparam int POS_BAD_DESC   = 14;

  localparam logic [CAUSE_W-1:0] CAUSE_IMPL =
      (CAUSE_W'(1) << POS_BLK_DONE) | (CAUSE_W'(1) << POS_EVT_WR_ERR) |
      (CAUSE_W'(1) << POS_DESC_RD)  | (CAUSE_W'(1) << POS_DATA_RD)    |
      (CAUSE_W'(1) << POS_DATA_WR)  | (CAUSE_W'(1) << POS_BAD_DESC);

  localparam logic [MODE_W-1:0] MODE_MSG   = MODE_W'(0);
  localparam logic [MODE_W-1:0] MODE_WIRED = MODE_W'(1);

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_MODE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cause_status_reg.sv
module cause_status_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status
);
  logic [W-1:0] status_q;

  // set has priority over clear so a coincident event survives
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= ((status_q & ~clr) | src) & IMPL;
  end

  assign status = status_q;
endmodule

// File: rtl/cause_cfg_regs.sv
module cause_cfg_regs
  import irq_cause_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      enable_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [W-1:0]      clr_o,
  output logic [W-1:0]      reg_rdata
);
  logic     wr_en;
  reg_sel_e sel;

  assign wr_en = reg_valid && reg_write;
  assign sel   = reg_sel_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_o <= '0;
      mode_o   <= MODE_WIRED;
    end else if (wr_en) begin
      case (sel)
        SEL_ENABLE: enable_o <= reg_wdata & IMPL;
        SEL_MODE:   mode_o   <= reg_wdata[MODE_W-1:0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en && sel == SEL_CLEAR) ? reg_wdata : '0;

  always_comb begin
    case (sel)
      SEL_STATUS: reg_rdata = status_i;
      SEL_ENABLE: reg_rdata = enable_o;
      SEL_MODE:   reg_rdata = W'(mode_o);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cause_irq_out.sv
module cause_irq_out
  import irq_cause_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      status,
  input  logic [W-1:0]      enable,
  input  logic [MODE_W-1:0] mode,
  output logic              irq_level,
  output logic              msg_valid,
  output logic [W-1:0]      msg_cause
);
  logic [W-1:0] eff, eff_q, rise;

  assign eff  = status & enable;
  assign rise = eff & ~eff_q;

  always_ff @(posedge clk) begin
    if (!rst_n) eff_q <= '0;
    else        eff_q <= eff;
  end

  assign irq_level = (mode == MODE_WIRED) && (|eff);
  assign msg_valid = (mode == MODE_MSG) && (|rise);
  assign msg_cause = msg_valid ? eff : '0;
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int W = CAUSE_W,
  parameter logic [W-1:0] IMPL = CAUSE_IMPL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_pulse,
  input  logic         reg_valid,
  input  logic         reg_write,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         irq_level,
  output logic         msg_valid,
  output logic [W-1:0] msg_cause
);
  logic [W-1:0]      status_w, enable_w, clr_w;
  logic [MODE_W-1:0] mode_w;

  cause_status_reg #(.W(W), .IMPL(IMPL)) u_status (
    .clk(clk), .rst_n(rst_n), .src(src_pulse), .clr(clr_w), .status(status_w)
  );

  cause_cfg_regs #(.W(W), .IMPL(IMPL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status_i(status_w),
    .enable_o(enable_w), .mode_o(mode_w), .clr_o(clr_w), .reg_rdata(reg_rdata)
  );

  cause_irq_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .status(status_w), .enable(enable_w),
    .mode(mode_w), .irq_level(irq_level), .msg_valid(msg_valid),
    .msg_cause(msg_cause)
  );
endmodule

// File: rtl/irq_cause_ctrl_chk.sv
module irq_cause_ctrl_chk
  import irq_cause_pkg::*;
#(
  parameter int W = 16,
  parameter logic [W-1:0] IMPL = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      src_pulse,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [1:0]        reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic              irq_level,
  input logic              msg_valid,
  input logic [W-1:0]      msg_cause,
  input logic [W-1:0]      status,
  input logic [W-1:0]      enable,
  input logic [MODE_W-1:0] mode
);
  logic clr_wr;
  assign clr_wr = reg_valid && reg_write && (reg_addr == 2'd2);

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_pulse & IMPL)) |=>
      ((status & $past(src_pulse & IMPL)) == $past(src_pulse & IMPL)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((status & $past(reg_wdata & ~src_pulse)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (|(reg_wdata & src_pulse & IMPL))) |=>
      ((status & $past(reg_wdata & src_pulse & IMPL)) ==
       $past(reg_wdata & src_pulse & IMPL)));

  p_level_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level && !(reg_valid && reg_write)) |=> irq_level);

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |-> (!irq_level && !msg_valid));

  p_msg_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((mode == MODE_MSG) && (msg_cause != '0)));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_level && msg_valid));
endmodule

bind irq_cause_ctrl irq_cause_ctrl_chk #(.W(W), .IMPL(IMPL)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_valid(reg_valid),
  .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_level(irq_level), .msg_valid(msg_valid), .msg_cause(msg_cause),
  .status(status_w), .enable(enable_w), .mode(mode_w)
);

// File: tb/irq_cause_ctrl_test.sv
`timescale 1ns/1ps
module irq_cause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_pulse = '0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, msg_cause;
  logic        irq_level, msg_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_valid(reg_valid),
    .reg_write(reg_write), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_level(irq_level), .msg_valid(msg_valid),
    .msg_cause(msg_cause)
  );

  typedef struct packed {
    logic [15:0] src;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] stat;
    logic        lvl;
    logic        msg;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{16'h0001, 1'b0, 2'd0, 16'h0000, 16'h0001, 1'b0, 1'b0, 4'd6}, // R6 disabled latch
    '{16'h0000, 1'b1, 2'd1, 16'hFFFF, 16'h0001, 1'b1, 1'b0, 4'd5}, // R5 enable raises level
    '{16'h0002, 1'b0, 2'd0, 16'h0000, 16'h0003, 1'b1, 1'b0, 4'd2}, // R2
    '{16'h0000, 1'b1, 2'd2, 16'h0000, 16'h0003, 1'b1, 1'b0, 4'd3}, // R3 zero clear
    '{16'h0000, 1'b1, 2'd2, 16'h0001, 16'h0002, 1'b1, 1'b0, 4'd5}, // R5 still high
    '{16'h0002, 1'b1, 2'd2, 16'h0002, 16'h0002, 1'b1, 1'b0, 4'd4}, // R4 set wins
    '{16'h0000, 1'b1, 2'd2, 16'h0002, 16'h0000, 1'b0, 1'b0, 4'd5}, // R5 drops
    '{16'h8000, 1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd2}, // R2 unimplemented
    '{16'h4E00, 1'b0, 2'd0, 16'h0000, 16'h4E00, 1'b1, 1'b0, 4'd2}, // R2 error bits
    '{16'h0000, 1'b1, 2'd3, 16'h0000, 16'h4E00, 1'b0, 1'b0, 4'd7}, // R7 message mode
    '{16'h0000, 1'b1, 2'd2, 16'h4E00, 16'h0000, 1'b0, 1'b0, 4'd3}, // R3
    '{16'h0200, 1'b0, 2'd0, 16'h0000, 16'h0200, 1'b0, 1'b1, 4'd7}, // R7 pulse
    '{16'h0400, 1'b0, 2'd0, 16'h0000, 16'h0600, 1'b0, 1'b1, 4'd7}, // R7 pulse again
    '{16'h0200, 1'b0, 2'd0, 16'h0000, 16'h0600, 1'b0, 1'b0, 4'd7}, // R7 no new rise
    '{16'h0000, 1'b1, 2'd1, 16'h0000, 16'h0600, 1'b0, 1'b0, 4'd6}, // R6 disable all
    '{16'h0001, 1'b0, 2'd0, 16'h0000, 16'h0601, 1'b0, 1'b0, 4'd6}, // R6 masked source
    '{16'h0000, 1'b1, 2'd1, 16'h0001, 16'h0601, 1'b0, 1'b1, 4'd7}, // R7 enable rise
    '{16'h0000, 1'b1, 2'd3, 16'h0005, 16'h0601, 1'b0, 1'b0, 4'd8}, // R8 other mode
    '{16'h0000, 1'b1, 2'd0, 16'h0000, 16'h0601, 1'b0, 1'b0, 4'd8}, // R8 status write ignored
    '{16'h0000, 1'b1, 2'd3, 16'h0011, 16'h0601, 1'b1, 1'b0, 4'd8}  // R8 low nibble only
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    src_pulse = '0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a; reg_valid = 1'b1; reg_write = 1'b0;
    #1 d = reg_rdata;
    reg_valid = 1'b0; reg_addr = 2'd0;
  endtask

  initial begin
    #(8.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    idle();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 16'h0000);
    rd(2'd1, d); chk("R1 enable", d, 16'h0000);
    rd(2'd3, d); chk("R1 mode", d, 16'h0001);
    chk("R1 irq_level", 16'(irq_level), 16'h0);
    chk("R1 msg_valid", 16'(msg_valid), 16'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_pulse = VEC[i].src; reg_valid = VEC[i].wr; reg_write = VEC[i].wr;
      reg_addr = VEC[i].addr; reg_wdata = VEC[i].wdata;
      @(negedge clk);
      idle();
      #1;
      chk($sformatf("R%0d vec%0d irq_level", VEC[i].req, i), 16'(irq_level), 16'(VEC[i].lvl));
      chk($sformatf("R%0d vec%0d msg_valid", VEC[i].req, i), 16'(msg_valid), 16'(VEC[i].msg));
      rd(2'd0, d);
      chk($sformatf("R%0d vec%0d status", VEC[i].req, i), d, VEC[i].stat);
    end

    // R8 enable keeps implemented bits only, mode upper bits read 0
    rd(2'd1, d); chk("R8 enable readback", d, 16'h0001);
    rd(2'd3, d); chk("R8 mode readback", d, 16'h0001);
    rd(2'd2, d); chk("R3 clear reads zero", d, 16'h0000);
    wr(2'd1, 16'hFFFF);
    rd(2'd1, d); chk("R8 enable mask", d, 16'h4E03);

    // R7 cause vector carried with the pulse
    wr(2'd3, 16'h0000);
    wr(2'd2, 16'hFFFF);
    @(negedge clk);
    src_pulse = 16'h0800;
    @(negedge clk);
    idle();
    #1;
    chk("R7 msg_valid on data write error", 16'(msg_valid), 16'h1);
    chk("R7 msg_cause", msg_cause, 16'h0800);
    chk("R7 irq_level low in message mode", 16'(irq_level), 16'h0);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 16'(msg_valid), 16'h0);
    chk("R7 msg_cause zero when idle", msg_cause, 16'h0000);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    rd(2'd0, d); chk("R1 status after reset", d, 16'h0000);
    rd(2'd3, d); chk("R1 mode after reset", d, 16'h0001);
    chk("R1 irq_level after reset", 16'(irq_level), 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule